// File: doc/BRIEF.md
# Carry-Conditional Byte ALU with Flag Register

This block is the arithmetic and logic datapath of a small 8-bit interrupt-oriented core. Each cycle the core presents an operation code, two byte operands and the current flag nibble. The block returns the byte result, the flag nibble it would produce and a per-flag write mask, all combinationally. Several rules differ from the common 8-bit convention. The byte increment and decrement used on memory are conditional on the carry. Logic operations copy result bits into N, V and C. Compare and negate set C to the inverse of Z.

The block also holds a 4-bit flag register. On a clock edge where the execute strobe is high, each flag whose mask bit is set takes its new value, and each other flag takes the value on `flags_in`. While the strobe is low the register holds. Operand A is the accumulator, Y, or the memory byte, depending on the operation. Operand B is the second source.

Top module: `cflag_alu`

## Requirements
- R1: Flag nibble bit 0 = C, bit 1 = Z, bit 2 = N, bit 3 = V. A synchronous active-high reset clears `flags_q` to 0. Operation codes are: 0 pass, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 negate, 6 compare, 7 Y increment, 8 Y decrement, 9 carry increment, 10 carry decrement, 11 XOR, 12 OR, 13 AND, 14 NOT, 15 rotate right, 16 rotate left.
- R2: Add and subtract return opa+opb and opa-opb and ignore the incoming C. Add-with-carry adds C. Subtract-with-borrow subtracts the inverse of C. For all four, the new C is the carry out, and on the subtracting ones C=1 means no borrow.
- R3: Those four operations write all of C, Z, N and V. V is the two's-complement signed overflow, Z is set when the result is zero, and N is result bit 7.
- R4: Carry increment returns opa+C. Carry decrement returns opa-(1-C), so with C=1 the byte is unchanged. The new C is the carry out for increment and the no-borrow indication for decrement. Both write C, Z and N only.
- R5: Y increment returns opa+1 and Y decrement returns opa-1. Both write C, Z and N, with C=1 exactly when the value wraps (FF to 00, or 00 to FF).
- R6: Compare returns opa-opb and writes Z and N from that difference, and sets C to the inverse of Z. V is not written.
- R7: Negate returns 0-opa and writes Z and N from it, and sets C to the inverse of Z. V is not written.
- R8: XOR, OR and AND combine opa with opb, and NOT inverts opa. They write N from result bit 7, V from bit 6 and C from bit 0. Z is not written.
- R9: Rotate right returns {C, opa[7:1]} with new C = opa[0]. Rotate left returns {opa[6:0], C} with new C = opa[7]. Both write C, Z and N.
- R10: Pass (code 0, and every unlisted code 17 to 31) returns opa and writes no flag.
- R11: `flag_next` carries the new value for each written flag and `flags_in` for each unwritten one. `flags_q` loads `flag_next` on a clock edge with `exec_en` high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| exec_en | input | 1 | Execute strobe; loads the flag register |
| op | input | 5 | Operation code (see R1) |
| opa | input | 8 | Operand A (accumulator, Y or memory byte) |
| opb | input | 8 | Operand B |
| flags_in | input | 4 | Current flags {V,N,Z,C} |
| result | output | 8 | Byte result, combinational |
| flag_next | output | 4 | Merged new flags, combinational |
| flag_we | output | 4 | Per-flag write mask, combinational |
| flags_q | output | 4 | Registered flags |

## Verification
`result`, `flag_next` and `flag_we` depend only on the present inputs, so they are valid in the same cycle the operands are applied. The bench samples them a fraction of a nanosecond after each change, always between clock edges. `flags_q` moves only at the first rising edge that sees `exec_en` high, so every register check drives at a falling edge and samples one nanosecond after the next rising edge. Each operation is swept over every operand value, and two-operand operations over every operand pair, under both carry values.

// File: rtl/cfalu_pkg.sv
`timescale 1ns/10ps
package cfalu_pkg;
  localparam int FLAG_W = 4;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SUB  = 5'd3,
    OP_SBC  = 5'd4,
    OP_NEG  = 5'd5,
    OP_CMP  = 5'd6,
    OP_INCY = 5'd7,
    OP_DECY = 5'd8,
    OP_CINC = 5'd9,
    OP_CDEC = 5'd10,
    OP_XOR  = 5'd11,
    OP_OR   = 5'd12,
    OP_AND  = 5'd13,
    OP_NOT  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ROL  = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/cfalu_addsub.sv
`timescale 1ns/10ps
module cfalu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/cfalu_logic.sv
`timescale 1ns/10ps
module cfalu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a ^ b;
      2'd1:    y = a | b;
      2'd2:    y = a & b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/cfalu_rot.sv
`timescale 1ns/10ps
module cfalu_rot #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         left,
  output logic [W-1:0] y,
  output logic         cout
);
  always_comb begin
    if (left) begin
      y    = {a[W-2:0], cin};
      cout = a[W-1];
    end else begin
      y    = {cin, a[W-1:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/cflag_alu.sv
`timescale 1ns/10ps
module cflag_alu
  import cfalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flag_next,
  output logic [FLAG_W-1:0] flag_we,
  output logic [FLAG_W-1:0] flags_q
);
  localparam int MSB = DATA_W - 1;
  localparam logic [MSB:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [FLAG_W-1:0] WE_ALL = 4'b1111;
  localparam logic [FLAG_W-1:0] WE_CZN = 4'b0111;
  localparam logic [FLAG_W-1:0] WE_CNV = 4'b1101;

  alu_op_e op_e;
  logic    cin_q;
  assign op_e  = alu_op_e'(op);
  assign cin_q = flags_in[FC];

  // operand steering for the single shared adder
  logic [MSB:0] ad_a, ad_b, ad_sum;
  logic         ad_cin, ad_sub, ad_cout, ad_ovf;

  always_comb begin
    ad_a   = opa;
    ad_b   = opb;
    ad_cin = 1'b0;
    ad_sub = 1'b0;
    case (op_e)
      OP_ADC: ad_cin = cin_q;
      OP_SUB, OP_CMP: begin
        ad_sub = 1'b1;
        ad_cin = 1'b1;
      end
      OP_SBC: begin
        ad_sub = 1'b1;
        ad_cin = cin_q;
      end
      OP_NEG: begin
        ad_a   = '0;
        ad_b   = opa;
        ad_sub = 1'b1;
        ad_cin = 1'b1;
      end
      OP_INCY: begin
        ad_b   = '0;
        ad_cin = 1'b1;
      end
      OP_DECY: begin
        ad_b   = ONE;
        ad_sub = 1'b1;
        ad_cin = 1'b1;
      end
      OP_CINC: begin
        ad_b   = '0;
        ad_cin = cin_q;
      end
      OP_CDEC: begin
        ad_b   = '0;
        ad_sub = 1'b1;
        ad_cin = cin_q;
      end
      default: ;
    endcase
  end

  cfalu_addsub #(.W(DATA_W)) u_addsub (
    .a    (ad_a),
    .b    (ad_b),
    .cin  (ad_cin),
    .sub  (ad_sub),
    .sum  (ad_sum),
    .cout (ad_cout),
    .ovf  (ad_ovf)
  );

  logic [1:0]   lg_sel;
  logic [MSB:0] lg_y;

  always_comb begin
    case (op_e)
      OP_XOR:  lg_sel = 2'd0;
      OP_OR:   lg_sel = 2'd1;
      OP_AND:  lg_sel = 2'd2;
      default: lg_sel = 2'd3;
    endcase
  end

  cfalu_logic #(.W(DATA_W)) u_logic (
    .a   (opa),
    .b   (opb),
    .sel (lg_sel),
    .y   (lg_y)
  );

  logic [MSB:0] rot_y;
  logic         rot_c;

  cfalu_rot #(.W(DATA_W)) u_rot (
    .a    (opa),
    .cin  (cin_q),
    .left (op_e == OP_ROL),
    .y    (rot_y),
    .cout (rot_c)
  );

  // result select and flag candidates
  logic [MSB:0]        res;
  logic [FLAG_W-1:0]   we;
  logic                c_new, v_new;
  flags_t              cand;

  always_comb begin
    res   = opa;
    we    = '0;
    c_new = cin_q;
    v_new = flags_in[FV];
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res   = ad_sum;
        c_new = ad_cout;
        v_new = ad_ovf;
        we    = WE_ALL;
      end
      OP_NEG, OP_CMP: begin
        res   = ad_sum;
        c_new = |ad_sum;
        we    = WE_CZN;
      end
      OP_INCY, OP_CINC, OP_CDEC: begin
        res   = ad_sum;
        c_new = ad_cout;
        we    = WE_CZN;
      end
      OP_DECY: begin
        res   = ad_sum;
        c_new = ~ad_cout;
        we    = WE_CZN;
      end
      OP_XOR, OP_OR, OP_AND, OP_NOT: begin
        res   = lg_y;
        c_new = lg_y[0];
        v_new = lg_y[MSB-1];
        we    = WE_CNV;
      end
      OP_ROR, OP_ROL: begin
        res   = rot_y;
        c_new = rot_c;
        we    = WE_CZN;
      end
      default: ;
    endcase
    cand.c = c_new;
    cand.z = ~|res;
    cand.n = res[MSB];
    cand.v = v_new;
  end

  assign result    = res;
  assign flag_we   = we;
  assign flag_next = (cand & we) | (flags_in & ~we);

  // flag register, one flop per flag
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)          q <= 1'b0;
      else if (exec_en) q <= flag_next[i];
    end
    assign flags_q[i] = q;
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (flags_q == '0));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(flags_q));

  p_cmp_c_inv_z_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |-> (flag_next[FC] != flag_next[FZ]));

  p_neg_c_inv_z_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NEG) |-> (flag_next[FC] != flag_next[FZ] && !flag_we[FV]));

  p_pass_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PASS) |-> (flag_we == '0 && result == opa && flag_next == flags_in));

  p_logic_keeps_z_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op == OP_XOR || op == OP_OR || op == OP_AND || op == OP_NOT))
      |=> (flags_q[FZ] == $past(flags_in[FZ])));

  p_ror_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ROR) |-> (flag_next[FC] == opa[0] && result[MSB] == flags_in[FC]));

  p_cdec_c_set_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CDEC && flags_in[FC]) |-> (result == opa && flag_next[FC]));

  p_incy_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INCY && opa == '1) |-> (flag_next[FC] && result == '0));
endmodule

// File: tb/cflag_alu_tb.sv
`timescale 1ns/10ps
module cflag_alu_tb;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic [3:0] flag_next, flag_we, flags_q;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cflag_alu #(.DATA_W(8)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .exec_en   (exec_en),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .flags_in  (flags_in),
    .result    (result),
    .flag_next (flag_next),
    .flag_we   (flag_we),
    .flags_q   (flags_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit uses_b(input int o);
    return (o >= 1 && o <= 4) || o == 6 || (o >= 11 && o <= 13);
  endfunction

  // arithmetic reference taken from the requirements
  function automatic void ref_model(input int o, input int a, input int b,
                                    input logic [3:0] fin, output int r,
                                    output logic [3:0] fn, output logic [3:0] we);
    int c, s, sa, sb, sr;
    c  = int'(fin[0]);
    fn = fin;
    we = 4'b0000;
    r  = a;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (o)
      1, 2: begin
        s  = a + b + ((o == 2) ? c : 0);
        sr = sa + sb + ((o == 2) ? c : 0);
        r  = s % 256;
        fn[0] = (s > 255);
        fn[3] = (sr > 127 || sr < -128);
        we = 4'b1111;
      end
      3, 4: begin
        s  = a - b - ((o == 4) ? 1 - c : 0);
        sr = sa - sb - ((o == 4) ? 1 - c : 0);
        r  = (s + 512) % 256;
        fn[0] = (s >= 0);
        fn[3] = (sr > 127 || sr < -128);
        we = 4'b1111;
      end
      5: begin r = (256 - a) % 256; fn[0] = (r != 0); we = 4'b0111; end
      6: begin r = (a - b + 256) % 256; fn[0] = (r != 0); we = 4'b0111; end
      7: begin r = (a + 1) % 256; fn[0] = (a == 255); we = 4'b0111; end
      8: begin r = (a + 255) % 256; fn[0] = (a == 0); we = 4'b0111; end
      9: begin s = a + c; r = s % 256; fn[0] = (s > 255); we = 4'b0111; end
      10: begin s = a - (1 - c); r = (s + 256) % 256; fn[0] = (s >= 0); we = 4'b0111; end
      11, 12, 13, 14: begin
        case (o)
          11: r = a ^ b;
          12: r = a | b;
          13: r = a & b;
          default: r = 255 - a;
        endcase
        fn[0] = (r % 2 == 1);
        fn[3] = ((r / 64) % 2 == 1);
        we = 4'b1101;
      end
      15: begin r = c * 128 + a / 2; fn[0] = (a % 2 == 1); we = 4'b0111; end
      16: begin r = (a * 2) % 256 + c; fn[0] = (a >= 128); we = 4'b0111; end
      default: ;
    endcase
    if (we[1]) fn[1] = (r == 0);
    if (we[2]) fn[2] = (r > 127);
  endfunction

  // one check per operation: every opa (and opb where used), both carries
  task automatic sweep_op(input int o, input string req);
    int bad = 0;
    logic [31:0] f_act = '0;
    logic [31:0] f_exp = '0;
    int blim = uses_b(o) ? 255 : 0;
    @(negedge clk);
    #0.05;
    for (int fi = 0; fi < 2; fi++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b <= blim; b++) begin
          int r;
          logic [3:0] fn, we;
          logic [3:0] fin;
          logic [31:0] act, exp;
          fin = (fi == 1) ? 4'b0101 : 4'b1010;
          op = o[4:0];
          opa = a[7:0];
          opb = b[7:0];
          flags_in = fin;
          #0.1;
          ref_model(o, a, b, fin, r, fn, we);
          act = {12'h0, o[3:0], result, flag_next, flag_we};
          exp = {12'h0, o[3:0], r[7:0], fn, we};
          if (act !== exp) begin
            if (bad == 0) begin
              f_act = act;
              f_exp = exp;
            end
            bad++;
          end
        end
      end
    end
    n_chk++;
    if (bad != 0) begin
      n_err++;
      $display("FAIL %s sweep op %0d ({op,result,flag_next,flag_we}) %0d mismatches: actual %0h expected %0h",
               req, o, bad, f_act, f_exp);
    end
  endtask

  task automatic exec_step(input logic [4:0] o, input logic [7:0] a,
                           input logic [7:0] b, input logic [3:0] fin,
                           input logic en);
    @(negedge clk);
    op = o;
    opa = a;
    opb = b;
    flags_in = fin;
    exec_en = en;
    @(posedge clk);
    #1;
    exec_en = 1'b0;
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "flags_q after reset", flags_q, 4'b0000);

    // R3: 7F + 01 overflows into the sign bit
    exec_step(5'd1, 8'h7F, 8'h01, 4'b0000, 1'b1);
    chk("R3", "add 7F+01 flags_q", flags_q, 4'b1100);

    // R11: strobe low leaves the register alone
    exec_step(5'd3, 8'h00, 8'h01, 4'b1111, 1'b0);
    chk("R11", "hold without exec_en", flags_q, 4'b1100);

    // R2/R3: 00 - 01 borrows
    exec_step(5'd3, 8'h00, 8'h01, 4'b0000, 1'b1);
    chk("R2", "sub 00-01 flags_q", flags_q, 4'b0100);
    chk("R2", "sub 00-01 result", result, 8'hFF);

    // R8: AND writes N,V,C from bits, Z kept from flags_in
    exec_step(5'd13, 8'h41, 8'hC1, 4'b0010, 1'b1);
    chk("R8", "and 41&C1 flags_q", flags_q, 4'b1011);

    // R10: pass writes nothing, register takes flags_in
    exec_step(5'd0, 8'h5A, 8'h00, 4'b0110, 1'b1);
    chk("R10", "pass flags_q", flags_q, 4'b0110);
    chk("R10", "pass result", result, 8'h5A);

    // R4: carry decrement of 00 with C=0 borrows, V kept
    exec_step(5'd10, 8'h00, 8'h00, 4'b1000, 1'b1);
    chk("R4", "cdec 00 C=0 flags_q", flags_q, 4'b1100);
    chk("R4", "cdec 00 C=0 result", result, 8'hFF);

    // R5: Y decrement from 00 wraps
    exec_step(5'd8, 8'h00, 8'h00, 4'b0000, 1'b1);
    chk("R5", "decy 00 flags_q", flags_q, 4'b0101);

    // R6: equal compare gives Z=1, C=0
    exec_step(5'd6, 8'h33, 8'h33, 4'b0001, 1'b1);
    chk("R6", "cmp equal flags_q", flags_q, 4'b0010);

    // R9: rotate left of 80 with C=0
    exec_step(5'd16, 8'h80, 8'h00, 4'b0000, 1'b1);
    chk("R9", "rol 80 flags_q", flags_q, 4'b0011);
    chk("R9", "rol 80 result", result, 8'h00);

    // R1: reset wins over a strobe
    @(negedge clk);
    rst = 1'b1;
    op = 5'd1;
    opa = 8'hFF;
    opb = 8'h01;
    flags_in = 4'b1111;
    exec_en = 1'b1;
    @(posedge clk);
    #1;
    exec_en = 1'b0;
    chk("R1", "reset over exec", flags_q, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    sweep_op(0, "R10");
    sweep_op(1, "R2");
    sweep_op(2, "R2");
    sweep_op(3, "R3");
    sweep_op(4, "R3");
    sweep_op(5, "R7");
    sweep_op(6, "R6");
    sweep_op(7, "R5");
    sweep_op(8, "R5");
    sweep_op(9, "R4");
    sweep_op(10, "R4");
    sweep_op(11, "R8");
    sweep_op(12, "R8");
    sweep_op(13, "R8");
    sweep_op(14, "R8");
    sweep_op(15, "R9");
    sweep_op(16, "R9");
    sweep_op(17, "R10");
    sweep_op(31, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule